// File: doc/BRIEF.md
# Out-of-Order Read Completion Reorder Buffer

This block sits on the host-to-device side of a DMA engine. Once started with a base address and a segment count, it issues read requests for consecutive fixed-size segments. Each request carries a tag equal to the index of the on-chip storage slot that will hold its data. Several requests can be in flight at once, so the host always has one queued and the round-trip gap does not throttle the stream. Completion beats may come back in any order, both between segments and within a segment. Each beat carries a tag and a byte offset, and is written straight into its slot. The slots are drained strictly in the order their requests were issued, as a 32-bit word stream with valid/ready backpressure.

The slot count is a parameter: 4, 8 or 16 slots of 512 bytes each. A count of 0 selects a pass-through mode. In that mode nothing is stored, only one request is outstanding at a time, and the next request goes out only after every beat of the previous one has been accepted. A beat whose tag names a slot that is not waiting for data is dropped. So is a beat whose offset is not word aligned. Either case raises a sticky error flag.

Top module: `rd_reorder_buf`

## Requirements
- R1: While and right after synchronous reset, `req_valid`, `out_valid` and `err` are low.
- R2: A `start` pulse while idle loads `base_addr` and `xfer_segs`. Exactly `xfer_segs` requests then follow, request k carrying address `base_addr + k*SEG_BYTES` and tag `k mod SLOTS`.
- R3: No more than SLOTS requests are outstanding at once. A request is outstanding from its acceptance until its slot is freed. With all slots outstanding and none complete, `req_valid` stays low.
- R4: Output words appear in issue order. Within a segment, word i is the completion data delivered with byte offset 4*i, whatever order the beats arrived in.
- R5: A segment is drained only after all SEG_BYTES/4 of its words have arrived. An incomplete older segment holds back younger segments that are already complete.
- R6: A slot is freed when its last word moves into the output register, and the slot's tag is then reissued for the next request.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold.
- R8: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr` and `req_tag` hold.
- R9: A beat whose tag names a slot that is free or already complete is dropped and leaves the output unchanged. So is a beat whose offset has nonzero bits [1:0]. Either sets `err`, which stays high until reset.
- R10: With SLOTS=0, `cpl_ready` is high only when the output register is empty or being consumed. Beats pass to the output in arrival order, and a new request is raised only after the previous segment's last beat has been accepted.
- R11: A reset in mid-transfer clears every slot and both pointers, and the next transfer's first request carries tag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (accepted when idle) |
| base_addr | input | ADDR_W | Address of the first segment |
| xfer_segs | input | LEN_W | Number of segments to request |
| req_valid | output | 1 | Read request pending |
| req_ready | input | 1 | Request accepted by the read interface |
| req_addr | output | ADDR_W | Segment address of the request |
| req_tag | output | TAG_W | Slot tag of the request |
| cpl_valid | input | 1 | Completion beat present |
| cpl_ready | output | 1 | Beat accepted (always high unless SLOTS=0) |
| cpl_tag | input | TAG_W | Tag of the beat |
| cpl_off | input | OFF_W | Byte offset of the beat within its segment |
| cpl_data | input | DATA_W | Beat data |
| out_valid | output | 1 | Ordered output word present |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | DATA_W | Ordered output word |
| err | output | 1 | Sticky flag for a dropped beat |

## Verification
The bench returns a group of segments in reverse order, and within alternate segments reverses the beat order too. A design that drained by completion order, or indexed words by arrival, would emit younger or scrambled data, and the scoreboard would flag it. It stalls the oldest segment while younger ones are complete and sends a beat to an already complete slot. A design that released early or accepted stray beats would show `out_valid` or corrupt data. It also checks tag reuse after drain, a mid-transfer reset, and the single-outstanding pass-through mode, where a design that issued early would raise a request before the last beat had been accepted.

// File: rtl/rd_reorder_pkg.sv
package rd_reorder_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_WAIT = 2'd1,
    SLOT_FULL = 2'd2
  } slot_st_t;
endpackage

// File: rtl/rd_reorder_issuer.sv
module rd_reorder_issuer #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int TAG_W     = 2,
  parameter int CAP       = 4,
  parameter int SEG_BYTES = 512,
  parameter int OCC_W     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [LEN_W-1:0]  xfer_segs,
  input  logic              req_ready,
  input  logic              seg_free,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic [TAG_W-1:0]  req_tag,
  output logic              issue_fire,
  output logic [OCC_W-1:0]  occ
);
  localparam logic [OCC_W-1:0] CAP_V    = OCC_W'(CAP);
  localparam logic [TAG_W-1:0] LAST_TAG = TAG_W'(CAP - 1);

  logic [ADDR_W-1:0] nxt_addr;
  logic [LEN_W-1:0]  left;
  logic [TAG_W-1:0]  ip;

  assign issue_fire = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid <= 1'b0;
      req_addr  <= '0;
      req_tag   <= '0;
      nxt_addr  <= '0;
      left      <= '0;
      ip        <= '0;
      occ       <= '0;
    end else begin
      if (start && left == '0 && occ == '0 && !req_valid) begin
        nxt_addr <= base_addr;
        left     <= xfer_segs;
      end
      if (issue_fire) begin
        req_valid <= 1'b0;
        nxt_addr  <= nxt_addr + ADDR_W'(SEG_BYTES);
        left      <= left - LEN_W'(1);
        ip        <= (ip == LAST_TAG) ? '0 : ip + TAG_W'(1);
      end else if (!req_valid && left != '0 && occ < CAP_V) begin
        req_valid <= 1'b1;
        req_addr  <= nxt_addr;
        req_tag   <= ip;
      end
      case ({issue_fire, seg_free})
        2'b10:   occ <= occ + OCC_W'(1);
        2'b01:   occ <= occ - OCC_W'(1);
        default: occ <= occ;
      endcase
    end
  end
endmodule

// File: rtl/rd_reorder_ram.sv
module rd_reorder_ram #(
  parameter int DW = 32,
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rd_reorder_track.sv
module rd_reorder_track
  import rd_reorder_pkg::*;
#(
  parameter int SLOTS  = 4,
  parameter int WORDS  = 128,
  parameter int TAG_W  = 2,
  parameter int WIDX_W = 7,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_fire,
  input  logic [TAG_W-1:0]  issue_tag,
  input  logic              cpl_valid,
  input  logic [TAG_W-1:0]  cpl_tag,
  input  logic [WIDX_W-1:0] cpl_widx,
  input  logic [DW-1:0]     cpl_data,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DW-1:0]     out_data,
  output logic              seg_free,
  output logic              bad_cpl
);
  localparam logic [WIDX_W-1:0] LAST_W = WIDX_W'(WORDS - 1);

  slot_st_t          st  [SLOTS];
  logic [WIDX_W-1:0] cnt [SLOTS];
  logic [TAG_W-1:0]  dp;
  logic [WIDX_W-1:0] rw;
  logic              hit, fetch;

  assign hit      = cpl_valid && st[cpl_tag] == SLOT_WAIT;
  assign bad_cpl  = cpl_valid && !hit;
  assign fetch    = st[dp] == SLOT_FULL && (!out_valid || out_ready);
  assign seg_free = fetch && rw == LAST_W;

  rd_reorder_ram #(.DW(DW), .AW(TAG_W + WIDX_W)) u_ram (
    .clk   (clk),
    .we    (hit),
    .waddr ({cpl_tag, cpl_widx}),
    .wdata (cpl_data),
    .re    (fetch),
    .raddr ({dp, rw}),
    .rdata (out_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SLOTS; i++) begin
        st[i]  <= SLOT_FREE;
        cnt[i] <= '0;
      end
      dp        <= '0;
      rw        <= '0;
      out_valid <= 1'b0;
    end else begin
      if (issue_fire) st[issue_tag] <= SLOT_WAIT;
      if (hit) begin
        if (cnt[cpl_tag] == LAST_W) begin
          cnt[cpl_tag] <= '0;
          st[cpl_tag]  <= SLOT_FULL;
        end else begin
          cnt[cpl_tag] <= cnt[cpl_tag] + WIDX_W'(1);
        end
      end
      if (fetch) begin
        if (seg_free) begin
          rw     <= '0;
          st[dp] <= SLOT_FREE;
          dp     <= dp + TAG_W'(1);
        end else begin
          rw <= rw + WIDX_W'(1);
        end
      end
      if (fetch)          out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rd_reorder_buf.sv
module rd_reorder_buf #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int DATA_W    = 32,
  parameter int SEG_BYTES = 512,
  parameter int SLOTS     = 4,
  localparam int TAG_W    = (SLOTS < 2) ? 1 : $clog2(SLOTS),
  localparam int OFF_W    = $clog2(SEG_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [LEN_W-1:0]  xfer_segs,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [TAG_W-1:0]  req_tag,
  input  logic              cpl_valid,
  output logic              cpl_ready,
  input  logic [TAG_W-1:0]  cpl_tag,
  input  logic [OFF_W-1:0]  cpl_off,
  input  logic [DATA_W-1:0] cpl_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              err
);
  localparam int BYTE_SH = $clog2(DATA_W / 8);
  localparam int WORDS   = SEG_BYTES / (DATA_W / 8);
  localparam int WIDX_W  = $clog2(WORDS);
  localparam int CAP     = (SLOTS == 0) ? 1 : SLOTS;
  localparam int OCC_W   = $clog2(CAP + 1);

  logic              issue_fire, seg_free, bad_cpl, aligned;
  logic [OCC_W-1:0]  occ;
  logic [WIDX_W-1:0] cpl_widx;

  assign aligned  = cpl_off[BYTE_SH-1:0] == '0;
  assign cpl_widx = cpl_off[OFF_W-1:BYTE_SH];

  rd_reorder_issuer #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .TAG_W(TAG_W), .CAP(CAP),
    .SEG_BYTES(SEG_BYTES), .OCC_W(OCC_W)
  ) u_issuer (
    .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
    .xfer_segs(xfer_segs), .req_ready(req_ready), .seg_free(seg_free),
    .req_valid(req_valid), .req_addr(req_addr), .req_tag(req_tag),
    .issue_fire(issue_fire), .occ(occ)
  );

  generate
    if (SLOTS != 0) begin : g_accel
      logic trk_bad;
      assign cpl_ready = 1'b1;
      assign bad_cpl   = trk_bad || (cpl_valid && !aligned);
      rd_reorder_track #(
        .SLOTS(SLOTS), .WORDS(WORDS), .TAG_W(TAG_W), .WIDX_W(WIDX_W), .DW(DATA_W)
      ) u_track (
        .clk(clk), .rst(rst), .issue_fire(issue_fire), .issue_tag(req_tag),
        .cpl_valid(cpl_valid && aligned), .cpl_tag(cpl_tag), .cpl_widx(cpl_widx),
        .cpl_data(cpl_data), .out_ready(out_ready), .out_valid(out_valid),
        .out_data(out_data), .seg_free(seg_free), .bad_cpl(trk_bad)
      );
    end else begin : g_pass
      logic [WIDX_W-1:0] pt_cnt;
      logic              acc, hit;
      assign cpl_ready = !out_valid || out_ready;
      assign acc       = cpl_valid && cpl_ready;
      assign hit       = acc && aligned && occ != '0 && cpl_tag == '0;
      assign bad_cpl   = acc && !hit;
      assign seg_free  = hit && pt_cnt == WIDX_W'(WORDS - 1);
      always_ff @(posedge clk) begin
        if (rst) begin
          pt_cnt    <= '0;
          out_valid <= 1'b0;
          out_data  <= '0;
        end else begin
          if (hit) begin
            pt_cnt    <= seg_free ? '0 : pt_cnt + WIDX_W'(1);
            out_valid <= 1'b1;
            out_data  <= cpl_data;
          end else if (out_ready) begin
            out_valid <= 1'b0;
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)          err <= 1'b0;
    else if (bad_cpl) err <= 1'b1;
  end
endmodule

// File: rtl/rd_reorder_chk.sv
module rd_reorder_chk #(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 2,
  parameter int DATA_W = 32,
  parameter int OCC_W  = 3,
  parameter int CAP    = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [TAG_W-1:0]  req_tag,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              err,
  input logic [OCC_W-1:0]  occ
);
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_tag));

  assert_out_hold_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  assert_occ_limit_R3: assert property (@(posedge clk) disable iff (rst)
    occ <= OCC_W'(CAP));

  assert_req_room_R3: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> occ < OCC_W'(CAP));
endmodule

bind rd_reorder_buf rd_reorder_chk #(
  .ADDR_W(ADDR_W), .TAG_W(TAG_W), .DATA_W(DATA_W), .OCC_W(OCC_W), .CAP(CAP)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_tag(req_tag), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .err(err), .occ(occ)
);

// File: tb/rd_reorder_buf_bench.sv
`timescale 1ns/100ps
module rd_reorder_buf_bench;
  localparam int WORDS = 128;
  localparam int SEG   = 512;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  int errors = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] f(input logic [31:0] a, input int w);
    return a ^ (32'(w) << 20) ^ 32'h5A00_0000;
  endfunction

  // accelerated instance (4 slots)
  logic        a_start = 0, a_req_valid, a_req_ready = 0, a_cpl_valid = 0, a_cpl_ready;
  logic        a_out_valid, a_out_ready = 0, a_err;
  logic [31:0] a_base = 0, a_req_addr, a_cpl_data = 0, a_out_data;
  logic [15:0] a_segs = 0;
  logic [1:0]  a_req_tag, a_cpl_tag = 0;
  logic [8:0]  a_cpl_off = 0;

  rd_reorder_buf u_rd_reorder_buf (
    .clk(clk), .rst(rst), .start(a_start), .base_addr(a_base), .xfer_segs(a_segs),
    .req_valid(a_req_valid), .req_ready(a_req_ready), .req_addr(a_req_addr), .req_tag(a_req_tag),
    .cpl_valid(a_cpl_valid), .cpl_ready(a_cpl_ready), .cpl_tag(a_cpl_tag), .cpl_off(a_cpl_off),
    .cpl_data(a_cpl_data), .out_valid(a_out_valid), .out_ready(a_out_ready),
    .out_data(a_out_data), .err(a_err)
  );

  // pass-through instance
  logic        p_start = 0, p_req_valid, p_req_ready = 1, p_cpl_valid = 0, p_cpl_ready;
  logic        p_out_valid, p_out_ready = 0, p_err;
  logic [31:0] p_base = 0, p_req_addr, p_cpl_data = 0, p_out_data;
  logic [15:0] p_segs = 0;
  logic [0:0]  p_req_tag, p_cpl_tag = 0;
  logic [8:0]  p_cpl_off = 0;

  rd_reorder_buf #(.SLOTS(0)) u_rd_reorder_buf_pt (
    .clk(clk), .rst(rst), .start(p_start), .base_addr(p_base), .xfer_segs(p_segs),
    .req_valid(p_req_valid), .req_ready(p_req_ready), .req_addr(p_req_addr), .req_tag(p_req_tag),
    .cpl_valid(p_cpl_valid), .cpl_ready(p_cpl_ready), .cpl_tag(p_cpl_tag), .cpl_off(p_cpl_off),
    .cpl_data(p_cpl_data), .out_valid(p_out_valid), .out_ready(p_out_ready),
    .out_data(p_out_data), .err(p_err)
  );

  logic [31:0] exp_q[$], pexp_q[$], log_addr[$], plog_addr[$];
  int          log_tag[$];
  int          nreq = 0, a_words = 0, a_drained = 0, pn = 0, p_words = 0, p_beats = 0;
  logic [31:0] exp_base = 0, pexp_base = 0;

  // request responder and scoreboard driver (accelerated)
  initial begin
    int rcyc = 0;
    bit rhold = 0;
    logic [31:0] hold_addr;
    logic [1:0]  hold_tag;
    forever begin
      @(negedge clk);
      a_req_ready = (rcyc % 3 != 1);
      rcyc++;
      #0.5;
      if (rhold && !rst) begin
        chk(a_req_valid && a_req_addr == hold_addr, "R8 addr held", a_req_addr, hold_addr);
        chk(a_req_tag == hold_tag, "R8 tag held", 32'(a_req_tag), 32'(hold_tag));
      end
      rhold = !rst && a_req_valid && !a_req_ready;
      hold_addr = a_req_addr;
      hold_tag = a_req_tag;
      if (!rst && a_req_valid && a_req_ready) begin
        chk(a_req_addr == exp_base + 32'(nreq * SEG), "R2 address", a_req_addr, exp_base + 32'(nreq * SEG));
        chk(32'(a_req_tag) == 32'(nreq % 4), (nreq >= 4) ? "R6 tag reuse" : "R2 tag",
            32'(a_req_tag), 32'(nreq % 4));
        log_addr.push_back(a_req_addr);
        log_tag.push_back(int'(a_req_tag));
        for (int w = 0; w < WORDS; w++) exp_q.push_back(f(a_req_addr, w));
        nreq++;
      end
    end
  end

  // output monitor (accelerated)
  initial begin
    int mcyc = 0;
    bit ohold = 0;
    logic [31:0] hold_d, e;
    forever begin
      @(negedge clk);
      a_out_ready = (mcyc % 4 != 3);
      mcyc++;
      #0.5;
      if (ohold && !rst) chk(a_out_valid && a_out_data == hold_d, "R7 output held", a_out_data, hold_d);
      ohold = !rst && a_out_valid && !a_out_ready;
      hold_d = a_out_data;
      if (!rst && a_out_valid && a_out_ready) begin
        if (exp_q.size() == 0) begin
          chk(0, "R4 unexpected word", a_out_data, 32'h0);
        end else begin
          e = exp_q.pop_front();
          chk(a_out_data == e, "R4 ordered data", a_out_data, e);
        end
        a_words++;
        if (a_words % WORDS == 0) a_drained++;
      end
    end
  end

  // pass-through request responder and monitor
  initial begin
    logic [31:0] e;
    int pcyc = 0;
    forever begin
      @(negedge clk);
      p_out_ready = (pcyc % 5 != 2);
      pcyc++;
      #0.5;
      if (!rst && p_req_valid && p_req_ready) begin
        chk(p_beats == pn * WORDS, "R10 single outstanding", 32'(p_beats), 32'(pn * WORDS));
        chk(p_req_addr == pexp_base + 32'(pn * SEG), "R10 address", p_req_addr, pexp_base + 32'(pn * SEG));
        plog_addr.push_back(p_req_addr);
        for (int w = 0; w < WORDS; w++) pexp_q.push_back(f(p_req_addr, w));
        pn++;
      end
      if (!rst && p_out_valid && p_out_ready) begin
        if (pexp_q.size() == 0) begin
          chk(0, "R10 unexpected word", p_out_data, 32'h0);
        end else begin
          e = pexp_q.pop_front();
          chk(p_out_data == e, "R10 arrival order data", p_out_data, e);
        end
        p_words++;
      end
    end
  end

  task automatic a_send(input int tag, input int off, input logic [31:0] d);
    a_cpl_valid = 1'b1;
    a_cpl_tag   = 2'(tag);
    a_cpl_off   = 9'(off);
    a_cpl_data  = d;
    @(negedge clk);
    a_cpl_valid = 1'b0;
  endtask

  task automatic a_seg(input int i, input bit rev);
    for (int w = 0; w < WORDS; w++) begin
      int ww = rev ? WORDS - 1 - w : w;
      a_send(log_tag[i], ww * 4, f(log_addr[i], ww));
    end
  endtask

  task automatic p_send(input int tag, input int off, input logic [31:0] d);
    bit acc;
    p_cpl_valid = 1'b1;
    p_cpl_tag   = 1'(tag);
    p_cpl_off   = 9'(off);
    p_cpl_data  = d;
    forever begin
      #1;
      acc = p_cpl_ready;
      @(negedge clk);
      if (acc) break;
    end
    p_cpl_valid = 1'b0;
    p_beats++;
  endtask

  task automatic run_all();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk(!a_req_valid && !p_req_valid, "R1 req_valid low in reset", 32'(a_req_valid), 0);
    chk(!a_out_valid && !p_out_valid, "R1 out_valid low in reset", 32'(a_out_valid), 0);
    chk(!a_err && !p_err, "R1 err low in reset", 32'(a_err), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!a_req_valid && !a_out_valid && !a_err, "R1 idle after reset", 32'(a_req_valid), 0);

    // accelerated: 8 segments, out-of-order completions
    exp_base = 32'h0001_0000;
    a_base = exp_base; a_segs = 16'd8; a_start = 1'b1;
    @(negedge clk);
    a_start = 1'b0;
    while (nreq < 4) @(negedge clk);
    repeat (8) @(negedge clk);
    chk(!a_req_valid, "R3 no request with all slots busy", 32'(a_req_valid), 0);
    chk(nreq == 4, "R3 outstanding count", 32'(nreq), 4);
    a_seg(3, 1); a_seg(2, 0); a_seg(1, 1);
    repeat (6) @(negedge clk);
    chk(!a_out_valid, "R5 oldest incomplete blocks drain", 32'(a_out_valid), 0);
    a_send(2, 0, 32'hDEAD_BEEF);
    chk(a_err, "R9 err on beat to full slot", 32'(a_err), 1);
    a_send(0, 2, 32'hBAD0_0000);
    chk(a_err && !a_out_valid, "R9 misaligned beat dropped, no output", 32'(a_out_valid), 0);
    a_seg(0, 1);
    for (int i = 4; i < 8; i++) begin
      while (nreq <= i) @(negedge clk);
      a_seg(i, i[0]);
    end
    while (a_drained < 8) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all words delivered", 32'(exp_q.size()), 0);
    chk(nreq == 8 && !a_req_valid, "R2 exactly xfer_segs requests", 32'(nreq), 8);
    chk(a_err, "R9 err stays set", 32'(a_err), 1);

    // mid-transfer reset
    exp_base = 32'h0004_0000;
    log_addr.delete(); log_tag.delete(); nreq = 0;
    a_base = exp_base; a_segs = 16'd3; a_start = 1'b1;
    @(negedge clk);
    a_start = 1'b0;
    while (nreq < 2) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    exp_q.delete(); log_addr.delete(); log_tag.delete();
    nreq = 0; a_words = 0; a_drained = 0;
    rst = 1'b0;
    @(negedge clk);
    chk(!a_err && !a_req_valid && !a_out_valid, "R11 cleared by reset", 32'(a_err), 0);
    exp_base = 32'h0008_0000;
    a_base = exp_base; a_segs = 16'd1; a_start = 1'b1;
    @(negedge clk);
    a_start = 1'b0;
    while (nreq < 1) @(negedge clk);
    chk(log_tag[0] == 0, "R11 first tag after reset", 32'(log_tag[0]), 0);
    a_seg(0, 0);
    while (a_drained < 1) @(negedge clk);
    chk(exp_q.size() == 0, "R11 transfer after reset completes", 32'(exp_q.size()), 0);

    // pass-through mode
    pexp_base = 32'h0002_0000;
    p_base = pexp_base; p_segs = 16'd3; p_start = 1'b1;
    @(negedge clk);
    p_start = 1'b0;
    for (int n = 0; n < 3; n++) begin
      while (pn <= n) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(!p_req_valid, "R10 no second request while outstanding", 32'(p_req_valid), 0);
      for (int w = 0; w < WORDS; w++) p_send(0, w * 4, f(plog_addr[n], w));
    end
    while (p_words < 3 * WORDS) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(pn == 3, "R10 request count", 32'(pn), 3);
    p_send(1, 0, 32'h1234_5678);
    repeat (2) @(negedge clk);
    chk(p_err && !p_out_valid, "R9 stray beat dropped in pass-through", 32'(p_out_valid), 0);
    chk(pexp_q.size() == 0, "R10 all words delivered", 32'(pexp_q.size()), 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule